// File: doc/BRIEF.md
# Averaging Period Measurement Unit

This block measures the period of a single square-wave input in system clock cycles. It averages a fixed number of those measurements and reports a signed error against a reference period. It is meant for a slowly varying tone, such as a vibrating string picked up by a comparator, where one full cycle resolves the period far better than counting cycles over a fixed time window.

The input first passes through a two-stage synchronizer and a rising-edge detector. A gate flips on every detected rising edge, so it stays high for exactly one input period. Clock cycles are counted only while the gate is high. As a result, every other input period produces one period sample. Thirty-two accepted samples are summed and divided by a shift to give the average. The error is that average minus the reference. A sample whose count saturates is flagged and dropped.

The reference can be written directly from a port. It can also be captured from the most recent average, so a hand-set tone can become the new target.

Top module: `period_avg_unit`

## Requirements
- R1: While reset is low and in the first cycle after it, errValid and ovfFlag are 0, avgOut and errOut are 0, and setpointOut equals the RESET_SP parameter.
- R2: The gate opens at the first rising input edge after reset. After that, opening and closing alternate on successive rising edges. The sample taken when the gate closes equals the number of clock cycles between the clock edges that first sample those two rising input edges.
- R3: Each run of 2**AVG_LOG2 accepted samples (32 by default) completes an average. An average is floor(sum / 2**AVG_LOG2) and is shown on avgOut. errValid is high for the single cycle that follows the second clock edge after the edge that first samples the closing rising input edge.
- R4: When errValid is high, errOut is avgOut minus the setpoint that was held before that update, as a CNT_W+1-bit two's complement number.
- R5: errValid is never high in two consecutive cycles. avgOut and errOut change only in a cycle where errValid is high.
- R6: A sample of 2**CNT_W cycles or more saturates the counter. It raises ovfFlag for one cycle, with the same timing as errValid, and does not count toward the 32.
- R7: setpointLoad high at a clock edge makes setpointOut equal setpointIn from the next cycle on.
- R8: captureReq high without setpointLoad at a clock edge copies the avgOut held before that edge into the setpoint. When both are high, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sqIn | input | 1 | Asynchronous square-wave input |
| setpointIn | input | CNT_W | Value written to the setpoint on a load |
| setpointLoad | input | 1 | Load setpointIn into the setpoint |
| captureReq | input | 1 | Copy the current average into the setpoint |
| avgOut | output | CNT_W | Most recent average period, in clock cycles |
| errOut | output | CNT_W+1 | Signed average minus setpoint |
| errValid | output | 1 | One-cycle strobe when a new average and error appear |
| ovfFlag | output | 1 | One-cycle strobe when a saturated sample is dropped |
| setpointOut | output | CNT_W | Current setpoint |

## Verification
A gate that loses its phase or a counter that is off by one shows up at the ports as an average off by a cycle or more. Because the per-cycle reference predicts every errValid and ovfFlag position, a gate in the wrong phase also moves those strobes by a full input period. A mistake in the sample count or the accumulator clear makes errValid fire early or late, and that shows at the first average, within 64 input periods. Setpoint mistakes show immediately on setpointOut, and again in the sign and size of the next errOut.

// File: rtl/prd_pkg.sv
`timescale 1ns/1ps
package prd_pkg;
  // strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic clrCnt;   // gate is opening: restart the period counter
    logic incCnt;   // gate is open and not closing: count this cycle
    logic accum;    // gate closing with a good count: add the sample
    logic finish;   // this sample completes the average
    logic ovf;      // gate closing with a saturated count: drop it
  } prdStrobes_t;
endpackage

// File: rtl/prd_ctrl.sv
`timescale 1ns/1ps
module prd_ctrl
  import prd_pkg::*;
#(
  parameter int AVG_LOG2 = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sqIn,
  input  logic        cntSat,
  output prdStrobes_t st
);
  localparam logic [AVG_LOG2-1:0] LAST_IDX = '1;

  logic syncA, syncB, syncPrev;
  logic rise, gate, endSample;
  logic [AVG_LOG2-1:0] sampleIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncA    <= sqIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign rise      = syncB & ~syncPrev;
  assign endSample = rise & gate;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gate <= 1'b0;
    else       gate <= gate ^ rise;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         sampleIdx <= '0;
    else if (st.accum) sampleIdx <= sampleIdx + 1'b1;
  end

  always_comb begin
    st.clrCnt = rise & ~gate;
    st.incCnt = gate & ~rise;
    st.accum  = endSample & ~cntSat;
    st.finish = endSample & ~cntSat & (sampleIdx == LAST_IDX);
    st.ovf    = endSample & cntSat;
  end

  AST_RISE_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    rise |=> !rise); // R2
  AST_FINISH_NEEDS_ACCUM: assert property (@(posedge clk) disable iff (!rstN)
    st.finish |-> (st.accum && !st.ovf)); // R3
endmodule

// File: rtl/prd_datapath.sv
`timescale 1ns/1ps
module prd_datapath
  import prd_pkg::*;
#(
  parameter int          CNT_W    = 21,
  parameter int          AVG_LOG2 = 5,
  parameter int unsigned RESET_SP = 0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  prdStrobes_t             st,
  input  logic [CNT_W-1:0]        setpointIn,
  input  logic                    setpointLoad,
  input  logic                    captureReq,
  output logic                    cntSat,
  output logic [CNT_W-1:0]        avgOut,
  output logic signed [CNT_W:0]   errOut,
  output logic                    errValid,
  output logic                    ovfFlag,
  output logic [CNT_W-1:0]        setpointOut
);
  localparam int ACC_W = CNT_W + AVG_LOG2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0]      cnt, sample, avgNext, spReg;
  logic [ACC_W-1:0]      acc, accNext;
  logic signed [CNT_W:0] errNext;

  assign cntSat  = (cnt == CNT_MAX);
  assign sample  = cnt + CNT_ONE;
  assign accNext = acc + {{AVG_LOG2{1'b0}}, sample};
  assign avgNext = CNT_W'(accNext >> AVG_LOG2);
  assign errNext = $signed({1'b0, avgNext}) - $signed({1'b0, spReg});

  // period counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     cnt <= '0;
    else if (st.clrCnt)            cnt <= '0;
    else if (st.incCnt && !cntSat) cnt <= sample;
  end

  // accumulator and results
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc      <= '0;
      avgOut   <= '0;
      errOut   <= '0;
      errValid <= 1'b0;
      ovfFlag  <= 1'b0;
    end else begin
      errValid <= st.finish;
      ovfFlag  <= st.ovf;
      if (st.finish) begin
        acc    <= '0;
        avgOut <= avgNext;
        errOut <= errNext;
      end else if (st.accum) begin
        acc <= accNext;
      end
    end
  end

  // setpoint register: load beats capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             spReg <= CNT_W'(RESET_SP);
    else if (setpointLoad) spReg <= setpointIn;
    else if (captureReq)   spReg <= avgOut;
  end
  assign setpointOut = spReg;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    errValid |=> !errValid); // R5
  AST_AVG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(avgOut) || !$stable(errOut)) |-> errValid); // R5
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (cntSat && !st.clrCnt) |=> cntSat); // R6
  AST_OVF_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(errValid && ovfFlag)); // R6
  AST_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    setpointLoad |=> (setpointOut == $past(setpointIn))); // R7
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (captureReq && !setpointLoad) |=> (setpointOut == $past(avgOut))); // R8
endmodule

// File: rtl/period_avg_unit.sv
`timescale 1ns/1ps
module period_avg_unit
  import prd_pkg::*;
#(
  parameter int          CNT_W    = 21,
  parameter int          AVG_LOG2 = 5,
  parameter int unsigned RESET_SP = 0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sqIn,
  input  logic [CNT_W-1:0]      setpointIn,
  input  logic                  setpointLoad,
  input  logic                  captureReq,
  output logic [CNT_W-1:0]      avgOut,
  output logic signed [CNT_W:0] errOut,
  output logic                  errValid,
  output logic                  ovfFlag,
  output logic [CNT_W-1:0]      setpointOut
);
  prdStrobes_t st;
  logic        cntSat;

  prd_ctrl #(.AVG_LOG2(AVG_LOG2)) u_ctrl (
    .clk(clk), .rstN(rstN), .sqIn(sqIn), .cntSat(cntSat), .st(st)
  );

  prd_datapath #(.CNT_W(CNT_W), .AVG_LOG2(AVG_LOG2), .RESET_SP(RESET_SP)) u_dp (
    .clk(clk), .rstN(rstN), .st(st),
    .setpointIn(setpointIn), .setpointLoad(setpointLoad), .captureReq(captureReq),
    .cntSat(cntSat), .avgOut(avgOut), .errOut(errOut), .errValid(errValid),
    .ovfFlag(ovfFlag), .setpointOut(setpointOut)
  );
endmodule

// File: tb/period_avg_unit_tb.sv
`timescale 1ns/1ps
module period_avg_unit_tb;
  localparam int W = 12;
  localparam int L = 5;
  localparam int N = 1 << L;
  localparam int RSP = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sqIn = 1'b0;
  logic [W-1:0] setpointIn = '0;
  logic setpointLoad = 1'b0;
  logic captureReq = 1'b0;
  logic [W-1:0] avgOut;
  logic signed [W:0] errOut;
  logic errValid, ovfFlag;
  logic [W-1:0] setpointOut;

  always #4 clk = ~clk;

  period_avg_unit #(.CNT_W(W), .AVG_LOG2(L), .RESET_SP(RSP)) u_dut (
    .clk(clk), .rstN(rstN), .sqIn(sqIn), .setpointIn(setpointIn),
    .setpointLoad(setpointLoad), .captureReq(captureReq), .avgOut(avgOut),
    .errOut(errOut), .errValid(errValid), .ovfFlag(ovfFlag), .setpointOut(setpointOut)
  );

  int passCnt = 0, totalCnt = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    totalCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
  endtask

  // behavioural reference model
  int k = 0, mSp = RSP, mAvg = 0, mErr = 0, mStart = 0;
  bit mPrev = 0, mPhase = 0, expValid = 0, expOvf = 0;
  int samples[$];
  int finAtQ[$], finAvgQ[$], ovfAtQ[$];
  int expValidTotal = 0, expOvfTotal = 0, seenValid = 0, seenOvf = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      k = 0; mSp = RSP; mAvg = 0; mErr = 0; mPrev = 0; mPhase = 0;
      expValid = 0; expOvf = 0;
    end else begin
      int oldSp, p, sum;
      k++;
      oldSp = mSp;
      if (setpointLoad) mSp = int'(setpointIn);
      else if (captureReq) mSp = mAvg;
      if (sqIn && !mPrev) begin
        if (!mPhase) begin
          mStart = k; mPhase = 1;
        end else begin
          p = k - mStart; mPhase = 0;
          if (p >= (1 << W)) begin
            ovfAtQ.push_back(k + 2); expOvfTotal++;
          end else begin
            samples.push_back(p);
            if (samples.size() == N) begin
              sum = 0;
              foreach (samples[i]) sum += samples[i];
              finAtQ.push_back(k + 2); finAvgQ.push_back(sum / N);
              samples.delete(); expValidTotal++;
            end
          end
        end
      end
      mPrev = sqIn;
      expValid = 0; expOvf = 0;
      if (finAtQ.size() > 0 && finAtQ[0] == k) begin
        void'(finAtQ.pop_front());
        mAvg = finAvgQ.pop_front();
        mErr = mAvg - oldSp;
        expValid = 1;
      end
      if (ovfAtQ.size() > 0 && ovfAtQ[0] == k) begin
        void'(ovfAtQ.pop_front());
        expOvf = 1;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(errValid == expValid, "R3 errValid", int'(errValid), int'(expValid));
      chk(ovfFlag == expOvf, "R6 ovfFlag", int'(ovfFlag), int'(expOvf));
      chk(int'(avgOut) == mAvg, "R3 avgOut", int'(avgOut), mAvg);
      chk(int'(errOut) == mErr, "R4 errOut", int'(errOut), mErr);
      chk(int'(setpointOut) == mSp, "R7 setpointOut", int'(setpointOut), mSp);
      if (errValid) seenValid++;
      if (ovfFlag) seenOvf++;
    end
  end

  task automatic sqPeriod(input int p);
    int h;
    h = p / 2;
    @(negedge clk) sqIn = 1'b1;
    repeat (h - 1) @(negedge clk);
    @(negedge clk) sqIn = 1'b0;
    repeat (p - h - 1) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", passCnt, totalCnt);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(errValid == 1'b0, "R1 errValid", int'(errValid), 0);
    chk(ovfFlag == 1'b0, "R1 ovfFlag", int'(ovfFlag), 0);
    chk(avgOut == '0, "R1 avgOut", int'(avgOut), 0);
    chk(errOut == '0, "R1 errOut", int'(errOut), 0);
    chk(int'(setpointOut) == RSP, "R1 setpointOut", int'(setpointOut), RSP);
    rstN = 1'b1;
    // R7: direct load
    @(negedge clk) begin setpointIn = 50; setpointLoad = 1'b1; end
    @(negedge clk) setpointLoad = 1'b0;
    chk(int'(setpointOut) == 50, "R7 load", int'(setpointOut), 50);
    // R2/R4: constant period, negative error
    repeat (66) sqPeriod(40);
    idle(5);
    chk(int'(avgOut) == 40, "R2 constant period average", int'(avgOut), 40);
    chk(int'(errOut) == -10, "R4 negative error", int'(errOut), -10);
    chk(seenValid == 1, "R5 one strobe per average", seenValid, 1);
    // R8: capture, then load wins over capture
    @(negedge clk) captureReq = 1'b1;
    @(negedge clk) captureReq = 1'b0;
    chk(int'(setpointOut) == 40, "R8 capture", int'(setpointOut), 40);
    @(negedge clk) begin setpointIn = 7; setpointLoad = 1'b1; captureReq = 1'b1; end
    @(negedge clk) begin setpointLoad = 1'b0; captureReq = 1'b0; end
    chk(int'(setpointOut) == 7, "R8 load beats capture", int'(setpointOut), 7);
    // R3/R4: varying periods, positive error
    for (int i = 0; i < 130; i++) sqPeriod(30 + (i * 7) % 23);
    idle(5);
    chk(int'(errOut) > 0, "R4 positive error", int'(errOut), 1);
    // R6: saturating periods around the limit
    sqPeriod(4200); sqPeriod(4200);
    sqPeriod(4096); sqPeriod(4096);
    sqPeriod(4095); sqPeriod(4095);
    for (int i = 0; i < 70; i++) sqPeriod(45 + (i % 3));
    idle(5);
    chk(seenOvf == expOvfTotal, "R6 dropped sample count", seenOvf, expOvfTotal);
    chk(expOvfTotal >= 2, "R6 overflow exercised", expOvfTotal, 2);
    chk(seenValid == expValidTotal, "R5 average count", seenValid, expValidTotal);
    done = 1'b1;
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end
endmodule